// File: doc/BRIEF.md
# Parallel Port Byte Download Controller

This block steers the download of bytes from a host over a strobe and acknowledge handshake into the storage path of an audio player. It is built as two nested state machines. An outer session machine opens a session when the host requests a download, and enters a transfer phase only when the downstream path reports that it can take data. Inside the transfer phase, an inner machine follows one byte at a time. It waits for the host strobe, then waits for the downstream side to signal that it has taken the byte, then drives the acknowledge until the strobe is released.

If the downstream ready flag drops, the session falls back to the port-ready state. If the request drops, it falls back to idle. In both cases the acknowledge is released. The host strobe is asynchronous, so it is synchronized before use. All three outputs come straight from flops.

Top module: `pport_dl_ctrl`

## Requirements
- R1: After reset, ack_n is 1, dl_mode is 0 and port_ready is 0, and the session is idle.
- R2: From idle, dl_req high at a clock edge moves the session to port-ready (port_ready 1, dl_mode 0) at that edge. From port-ready, dl_req low returns it to idle.
- R3: From port-ready, the transfer phase (dl_mode 1) is entered only at an edge where dl_req and sink_rdy are both high. Otherwise dl_mode stays 0.
- R4: In the transfer phase, dl_req low at an edge returns the session to idle at that edge: dl_mode 0, port_ready 0, ack_n 1.
- R5: In the transfer phase, sink_rdy low with dl_req high returns the session to port-ready at that edge: port_ready 1, dl_mode 0, ack_n 1.
- R6: host_strobe_n goes through a two-flop synchronizer. A level sampled at rising edge k first affects the handshake state at edge k+2.
- R7: In the transfer phase, a synchronized low strobe moves the byte machine from waiting to holding. From holding, next_byte high moves it to acknowledging, and next_byte low keeps it holding. ack_n is 0 only while acknowledging.
- R8: While acknowledging, a synchronized high strobe returns the byte machine to waiting, and ack_n goes back to 1 at that edge. A synchronized low strobe keeps ack_n at 0.
- R9: Every entry into the transfer phase from port-ready starts the byte machine in waiting (ack_n 1), whatever state it was in before the abort.
- R10: dl_mode is 1 exactly in the transfer phase. port_ready is 1 in port-ready and in the transfer phase. All outputs are registered and change on the same edge as the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dl_req | input | 1 | Host download request |
| sink_rdy | input | 1 | Downstream path can take data |
| host_strobe_n | input | 1 | Host byte strobe, active low, asynchronous |
| next_byte | input | 1 | Downstream has taken the current byte |
| ack_n | output | 1 | Byte acknowledge to host, active low |
| dl_mode | output | 1 | High while in the transfer phase |
| port_ready | output | 1 | High in port-ready and in the transfer phase |

## Verification
Directed sequences cover the points where state and timing are easy to get wrong:
- A full byte cycle whose strobe edges show the two-cycle synchronizer delay, separating a strobe that is used raw from one that is synchronized.
- A next_byte pulse given before the strobe has been seen.
- Aborts from the acknowledging state by request loss and by ready loss, which show whether ack_n is released on the same edge.
- A re-entry after an abort, which tells a sub-machine that restarts apart from one that resumes.

Biased random stimulus then keeps the request and ready flags mostly high while the strobe and next_byte toggle freely. This reaches every state pair, including aborts in the middle of a handshake. Each cycle is checked against a reference model in the bench.

// File: rtl/pport_dl_pkg.sv
package pport_dl_pkg;
  typedef enum logic [1:0] {
    SES_IDLE = 2'd0,
    SES_PRDY = 2'd1,
    SES_XFER = 2'd2
  } ses_state_t;

  typedef enum logic [1:0] {
    BYT_WAIT = 2'd0,
    BYT_HELD = 2'd1,
    BYT_ACK  = 2'd2
  } byte_state_t;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pport_session.sv
module pport_session
  import pport_dl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       rdy,
  output ses_state_t ses_q,
  output ses_state_t ses_d
);
  always_comb begin
    ses_d = ses_q;
    unique case (ses_q)
      SES_IDLE: if (req) ses_d = SES_PRDY;
      SES_PRDY: begin
        if (!req)     ses_d = SES_IDLE;
        else if (rdy) ses_d = SES_XFER;
      end
      SES_XFER: begin
        if (!req)      ses_d = SES_IDLE;
        else if (!rdy) ses_d = SES_PRDY;
      end
      default: ses_d = SES_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ses_q <= SES_IDLE;
    else        ses_q <= ses_d;
  end

  assert_enter_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ses_q == SES_PRDY && !(req && rdy)) |=> ses_q != SES_XFER);

  assert_abort_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ses_q == SES_XFER && !req) |=> ses_q == SES_IDLE);

  assert_idle_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ses_q == SES_IDLE) |=> ses_q != SES_XFER);
endmodule

// File: rtl/pport_byte_fsm.sv
module pport_byte_fsm
  import pport_dl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ses_state_t  ses_q,
  input  ses_state_t  ses_d,
  input  logic        stb_n_s,
  input  logic        nxt,
  output byte_state_t byt_q,
  output byte_state_t byt_d
);
  logic stay_xfer;
  assign stay_xfer = (ses_q == SES_XFER) && (ses_d == SES_XFER);

  always_comb begin
    byt_d = BYT_WAIT;
    if (stay_xfer) begin
      byt_d = byt_q;
      unique case (byt_q)
        BYT_WAIT: if (!stb_n_s) byt_d = BYT_HELD;
        BYT_HELD: if (nxt)      byt_d = BYT_ACK;
        BYT_ACK:  if (stb_n_s)  byt_d = BYT_WAIT;
        default:                byt_d = BYT_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byt_q <= BYT_WAIT;
    else        byt_q <= byt_d;
  end

  assert_entry_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ses_q == SES_PRDY && ses_d == SES_XFER) |=> byt_q == BYT_WAIT);

  assert_hold_without_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stay_xfer && byt_q == BYT_HELD && !nxt) |=> byt_q == BYT_HELD);
endmodule

// File: rtl/pport_dl_ctrl.sv
module pport_dl_ctrl
  import pport_dl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dl_req,
  input  logic sink_rdy,
  input  logic host_strobe_n,
  input  logic next_byte,
  output logic ack_n,
  output logic dl_mode,
  output logic port_ready
);
  logic        rst_core_n;
  logic        stb_n_s;
  ses_state_t  ses_q, ses_d;
  byte_state_t byt_q, byt_d;

  pport_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_core_n)
  );

  pport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stb_sync (
    .clk(clk), .rst_n(rst_core_n), .d(host_strobe_n), .q(stb_n_s)
  );

  pport_session u_session (
    .clk(clk), .rst_n(rst_core_n), .req(dl_req), .rdy(sink_rdy),
    .ses_q(ses_q), .ses_d(ses_d)
  );

  pport_byte_fsm u_byte (
    .clk(clk), .rst_n(rst_core_n), .ses_q(ses_q), .ses_d(ses_d),
    .stb_n_s(stb_n_s), .nxt(next_byte), .byt_q(byt_q), .byt_d(byt_d)
  );

  logic ack_n_d, mode_d, ready_d;
  always_comb begin
    mode_d  = (ses_d == SES_XFER);
    ready_d = (ses_d != SES_IDLE);
    ack_n_d = !(mode_d && byt_d == BYT_ACK);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ack_n      <= 1'b1;
      dl_mode    <= 1'b0;
      port_ready <= 1'b0;
    end else begin
      ack_n      <= ack_n_d;
      dl_mode    <= mode_d;
      port_ready <= ready_d;
    end
  end

  assert_mode_ready_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    dl_mode |-> port_ready);

  assert_ack_in_xfer_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    !ack_n |-> dl_mode);

  assert_ready_loss_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dl_mode && dl_req && !sink_rdy) |=> (port_ready && !dl_mode && ack_n));

  assert_req_loss_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dl_mode && !dl_req) |=> (!port_ready && ack_n));
endmodule

// File: tb/pport_dl_ctrl_tb.sv
`timescale 1ns/1ps
module pport_dl_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic dl_req, sink_rdy, host_strobe_n, next_byte;
  logic ack_n, dl_mode, port_ready;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pport_dl_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .dl_req(dl_req), .sink_rdy(sink_rdy),
    .host_strobe_n(host_strobe_n), .next_byte(next_byte),
    .ack_n(ack_n), .dl_mode(dl_mode), .port_ready(port_ready)
  );

  // reference model: session 0 idle, 1 port-ready, 2 transfer; byte 0 wait, 1 held, 2 ack
  int m_ses = 0;
  int m_byt = 0;
  bit m_s1 = 1'b1;
  bit m_s2 = 1'b1;

  function automatic bit exp_ack_n();
    return !(m_ses == 2 && m_byt == 2);
  endfunction
  function automatic bit exp_mode();
    return m_ses == 2;
  endfunction
  function automatic bit exp_ready();
    return m_ses != 0;
  endfunction

  task automatic model_step(bit req, bit rdy, bit stb, bit nxt);
    int ns = m_ses;
    int nb = m_byt;
    case (m_ses)
      0: if (req) ns = 1;
      1: if (!req) ns = 0; else if (rdy) begin ns = 2; nb = 0; end
      default: begin
        if (!req) ns = 0;
        else if (!rdy) ns = 1;
        else case (m_byt)
          0: if (!m_s2) nb = 1;
          1: if (nxt) nb = 2;
          default: if (m_s2) nb = 0;
        endcase
      end
    endcase
    if (ns != 2) nb = 0;
    m_ses = ns;
    m_byt = nb;
    m_s2 = m_s1;
    m_s1 = stb;
  endtask

  task automatic check(string tag, string what, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag, bit a, bit m, bit r);
    check(tag, "ack_n", ack_n, a);
    check(tag, "dl_mode", dl_mode, m);
    check(tag, "port_ready", port_ready, r);
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(bit req, bit rdy, bit stb, bit nxt);
    dl_req = req; sink_rdy = rdy; host_strobe_n = stb; next_byte = nxt;
    @(posedge clk);
    #1;
    model_step(req, rdy, stb, nxt);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; dl_req = 0; sink_rdy = 0; host_strobe_n = 1; next_byte = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1", 1, 0, 0);

    step(1, 0, 1, 0); check_all("R2", 1, 0, 1);
    step(1, 0, 1, 0); check("R3", "dl_mode", dl_mode, 0);
    step(0, 1, 1, 0); check_all("R2", 1, 0, 0);
    step(1, 1, 1, 0); check_all("R2", 1, 0, 1);
    step(1, 1, 1, 0); check_all("R3", 1, 1, 1);
    // strobe low: sampled at E1, used at E3
    step(1, 1, 0, 1); check("R6", "ack_n", ack_n, 1);
    step(1, 1, 0, 1); check("R6", "ack_n", ack_n, 1);
    step(1, 1, 0, 0); check("R7", "ack_n", ack_n, 1);
    step(1, 1, 0, 0); check("R7", "ack_n", ack_n, 1);
    step(1, 1, 0, 1); check("R7", "ack_n", ack_n, 0);
    step(1, 1, 1, 0); check("R8", "ack_n", ack_n, 0);
    step(1, 1, 1, 0); check("R8", "ack_n", ack_n, 0);
    step(1, 1, 1, 0); check("R8", "ack_n", ack_n, 1);
    // reach ack again, then drop request
    step(1, 1, 0, 0); step(1, 1, 0, 0); step(1, 1, 0, 0);
    step(1, 1, 0, 1); check("R7", "ack_n", ack_n, 0);
    step(0, 1, 0, 1); check_all("R4", 1, 0, 0);
    // reach ack, then drop ready
    step(1, 1, 0, 1); step(1, 1, 0, 1); step(1, 1, 0, 1);
    step(1, 1, 0, 1); check("R7", "ack_n", ack_n, 0);
    step(1, 0, 0, 1); check_all("R5", 1, 0, 1);
    step(1, 0, 1, 1); step(1, 0, 1, 1); check_all("R5", 1, 0, 1);
    step(1, 1, 1, 1); check_all("R9", 1, 1, 1);
    step(1, 1, 1, 1); check("R9", "ack_n", ack_n, 1);

    for (int i = 0; i < 4000; i++) begin
      bit rq = ($urandom % 100) < 93;
      bit rd = ($urandom % 100) < 88;
      bit sb = ($urandom % 100) < 50;
      bit nx = ($urandom % 100) < 40;
      step(rq, rd, sb, nx);
      check("R7", "ack_n", ack_n, exp_ack_n());
      check("R10", "dl_mode", dl_mode, exp_mode());
      check("R10", "port_ready", port_ready, exp_ready());
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule